// File: doc/BRIEF.md
# Serial Configuration EEPROM Loader

This block fetches a configuration image from a three-wire serial EEPROM (chip select, serial clock, a command/data line toward the memory and a data line back from it) and writes the image into a neighbouring configuration register file, one byte per write strobe. A load begins when the reset controller raises one of two request pulses. A full request follows a power-on or reset-pin event and loads the whole configuration region. A MAC request follows a USB bus reset and reloads only the six bytes of the 48-bit MAC address. Both scopes issue one sequential read that starts at EEPROM address 0.

The first byte returned is a signature. When it equals 0xA5, every later byte of the selected scope is written to the register file, and the register address equals the byte's offset in the image. When it differs, the loader ends the transfer after that byte and writes nothing, so the register file keeps its hardware defaults. The serial clock is derived from the system clock by a half-period count. Separate wait counts stretch the chip-select setup before the first rising clock edge and the chip-select hold after the last falling edge. These counts are set to meet the memory's timing minimums at the system clock rate.

The controller has six states. IDLE waits for a request. CS_SETUP raises chip select and waits. SK_LOW holds the clock low and samples at its last cycle. SK_HIGH holds the clock high. CS_HOLD waits with the clock low after the last bit. FINISH drops chip select and reports. The transitions are: IDLE to CS_SETUP on a request; CS_SETUP to SK_LOW when the setup count expires; SK_LOW to SK_HIGH when the half period expires; SK_HIGH to SK_LOW while bits remain; SK_HIGH to CS_HOLD after the last bit or after a signature mismatch; CS_HOLD to FINISH when the hold count expires; FINISH to IDLE unconditionally.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: While reset is asserted, and afterwards until a request arrives, eep_cs, eep_sk, busy, done, sig_ok and cfg_we are all 0.
- R2: Each load sends a read command on eep_do, most significant bit first: the start bit 1, the opcode bits 1 then 0, and then ADDR_W address bits, all 0. eep_do changes only while eep_sk is low.
- R3: eep_sk is never high while eep_cs is low. eep_cs is high for at least CS_SETUP_CYC cycles before the first rising edge of eep_sk. eep_cs stays high for at least CS_HOLD_CYC cycles after the last falling edge of eep_sk.
- R4: After the command, each bit on eep_di is taken in the last cycle of a low clock phase, one bit per clock period. Bytes arrive most significant bit first and at consecutive EEPROM addresses starting from 0. A load clocks CMD_BITS + 8 × (bytes read) rising edges, where CMD_BITS = 3 + ADDR_W.
- R5: With a full request and a first byte of 0xA5, the loader reads IMG_BYTES bytes. It then issues IMG_BYTES−1 single-cycle cfg_we strobes in ascending order, and each strobe carries cfg_addr = k and cfg_wdata = the byte at offset k, for k = 1 to IMG_BYTES−1.
- R6: When the first byte is not 0xA5, the loader reads only that byte, issues no cfg_we strobe, and finishes with sig_ok = 0.
- R7: A MAC request reads 7 bytes. When the signature is 0xA5, it writes only offsets 1 to 6, in that order.
- R8: busy stays high for exactly CS_SETUP_CYC + 2·HALF_CYC·(rising edges) + CS_HOLD_CYC + 1 cycles. done then rises, and busy and done are never high together.
- R9: A request that arrives while busy is high has no effect on the running load. When both requests are high in the same idle cycle, the full scope is used.
- R10: An accepted request clears done and sig_ok in the cycle it is accepted. On completion, sig_ok reports whether the signature matched, and both flags then hold until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_full_req | input | 1 | Pulse: load the whole configuration region |
| load_mac_req | input | 1 | Pulse: reload only the MAC address bytes |
| eep_di | input | 1 | Serial data from the EEPROM |
| eep_cs | output | 1 | EEPROM chip select, active high |
| eep_sk | output | 1 | EEPROM serial clock |
| eep_do | output | 1 | Command bits toward the EEPROM |
| busy | output | 1 | A load is in progress |
| done | output | 1 | The last load has finished |
| sig_ok | output | 1 | The last load found a valid signature |
| cfg_we | output | 1 | Register file write strobe |
| cfg_addr | output | $clog2(IMG_BYTES) | Register file byte offset |
| cfg_wdata | output | 8 | Register file write data |

## Verification
The assertions assume that request inputs are single-cycle pulses. They also assume that eep_di changes only just after a rising eep_sk edge, so it is settled long before the sampling cycle at the end of each low phase. The bench's EEPROM model follows this rule: it updates its output only on rising eep_sk, and it restarts its command decoder whenever eep_cs falls. The assertions further assume IMG_BYTES of at least 7 and no more than 2^ADDR_W. The bench configuration keeps within both limits.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CS_SETUP,
        ST_SK_LOW,
        ST_SK_HIGH,
        ST_CS_HOLD,
        ST_FINISH
    } ldr_state_t;

    typedef enum logic {
        SCOPE_FULL = 1'b0,
        SCOPE_MAC  = 1'b1
    } ldr_scope_t;

    // Signature expected in byte 0 of the image
    localparam logic [7:0] IMG_SIGNATURE = 8'hA5;
    // Start bit followed by the two-bit read opcode
    localparam logic [2:0] READ_CMD = 3'b110;
    // MAC address occupies image offsets 1..6
    localparam int MAC_LAST_BYTE = 6;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/cfgl_wait.sv
module cfgl_wait #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // R8 a fresh count never starts from an expired timer mid-load
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(cnt) == '0 && !$past(load)) |-> (cnt == '0));

endmodule

// File: rtl/cfgl_shifter.sv
module cfgl_shifter
    import cfgl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic             advance,
    input  logic             di,
    output logic             do_bit,
    output logic             in_data,
    output logic             byte_last_bit,
    output logic [CNT_W-1:0] byte_num,
    output logic [CNT_W-1:0] bit_idx,
    output logic [7:0]       rx_byte
);

    localparam int CMD_BITS = 3 + ADDR_W;
    localparam logic [CNT_W-1:0] CMD_BITS_C = CNT_W'(CMD_BITS);

    logic [CMD_BITS-1:0] cmd_sh;
    logic [6:0]          rx_hold;
    logic [CNT_W-1:0]    data_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
            cmd_sh  <= '0;
            rx_hold <= '0;
        end else if (clear) begin
            bit_idx <= '0;
            cmd_sh  <= {READ_CMD, {ADDR_W{1'b0}}};
            rx_hold <= '0;
        end else begin
            if (advance) begin
                bit_idx <= bit_idx + 1'b1;
                cmd_sh  <= {cmd_sh[CMD_BITS-2:0], 1'b0};
            end
            if (sample) begin
                rx_hold <= rx_byte[6:0];
            end
        end
    end

    always_comb begin
        in_data       = (bit_idx >= CMD_BITS_C);
        data_idx      = bit_idx - CMD_BITS_C;
        byte_num      = data_idx >> 3;
        byte_last_bit = in_data && (data_idx[2:0] == 3'b111);
        do_bit        = in_data ? 1'b0 : cmd_sh[CMD_BITS-1];
        rx_byte       = {rx_hold, di};
    end

    // R2 the first bit after a new command is loaded is the start bit
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear) |-> do_bit);

    // R4 the bit index moves by at most one per cycle
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clear) && !$past(advance)) |-> $stable(bit_idx));

endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader
    import cfgl_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int IMG_BYTES    = 32,
    parameter int HALF_CYC     = 4,
    parameter int CS_SETUP_CYC = 60,
    parameter int CS_HOLD_CYC  = 2,
    localparam int REG_AW      = $clog2(IMG_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_full_req,
    input  logic              load_mac_req,
    input  logic              eep_di,
    output logic              eep_cs,
    output logic              eep_sk,
    output logic              eep_do,
    output logic              busy,
    output logic              done,
    output logic              sig_ok,
    output logic              cfg_we,
    output logic [REG_AW-1:0] cfg_addr,
    output logic [7:0]        cfg_wdata
);

    localparam int CMD_BITS  = 3 + ADDR_W;
    localparam int FULL_BITS = CMD_BITS + 8 * IMG_BYTES;
    localparam int MAC_BITS  = CMD_BITS + 8 * (MAC_LAST_BYTE + 1);
    localparam int CNT_W     = $clog2(FULL_BITS + 1);
    localparam int TMR_MAX   = max3(HALF_CYC, CS_SETUP_CYC, CS_HOLD_CYC);
    localparam int TMR_W     = $clog2(TMR_MAX + 1);

    ldr_state_t state, state_n;
    ldr_scope_t scope;

    logic             tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic             sh_clear, sh_sample, sh_advance;
    logic             do_bit, in_data, byte_last_bit;
    logic [CNT_W-1:0] byte_num, bit_idx, end_bits;
    logic [7:0]       rx_byte;
    logic             sig_good, sig_bad;
    logic             req_any, last_bit;

    assign req_any  = load_full_req || load_mac_req;
    assign last_bit = (bit_idx == end_bits - 1'b1);

    cfgl_wait #(.W(TMR_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    cfgl_shifter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_shift (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear         (sh_clear),
        .sample        (sh_sample),
        .advance       (sh_advance),
        .di            (eep_di),
        .do_bit        (do_bit),
        .in_data       (in_data),
        .byte_last_bit (byte_last_bit),
        .byte_num      (byte_num),
        .bit_idx       (bit_idx),
        .rx_byte       (rx_byte)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Next state and sequencing strobes
    always_comb begin
        state_n    = state;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        sh_clear   = 1'b0;
        sh_sample  = 1'b0;
        sh_advance = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_any) begin
                    state_n  = ST_CS_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(CS_SETUP_CYC - 1);
                    sh_clear = 1'b1;
                end
            end
            ST_CS_SETUP: begin
                if (tmr_zero) begin
                    state_n  = ST_SK_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(HALF_CYC - 1);
                end
            end
            ST_SK_LOW: begin
                if (tmr_zero) begin
                    state_n   = ST_SK_HIGH;
                    sh_sample = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(HALF_CYC - 1);
                end
            end
            ST_SK_HIGH: begin
                if (tmr_zero) begin
                    sh_advance = 1'b1;
                    tmr_load   = 1'b1;
                    if (last_bit || sig_bad) begin
                        state_n = ST_CS_HOLD;
                        tmr_val = TMR_W'(CS_HOLD_CYC - 1);
                    end else begin
                        state_n = ST_SK_LOW;
                        tmr_val = TMR_W'(HALF_CYC - 1);
                    end
                end
            end
            ST_CS_HOLD: begin
                if (tmr_zero) begin
                    state_n = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_n = ST_IDLE;
            end
            default: begin
                state_n = ST_IDLE;
            end
        endcase
    end

    // Pin and status outputs decoded from the state
    always_comb begin
        eep_cs = 1'b0;
        eep_sk = 1'b0;
        busy   = 1'b1;
        unique case (state)
            ST_IDLE:     busy = 1'b0;
            ST_CS_SETUP: eep_cs = 1'b1;
            ST_SK_LOW:   eep_cs = 1'b1;
            ST_SK_HIGH: begin
                eep_cs = 1'b1;
                eep_sk = 1'b1;
            end
            ST_CS_HOLD:  eep_cs = 1'b1;
            ST_FINISH:   eep_cs = 1'b0;
            default:     busy = 1'b0;
        endcase
        eep_do = do_bit;
    end

    // Load bookkeeping: scope, signature decision, writes, completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scope     <= SCOPE_FULL;
            end_bits  <= CNT_W'(FULL_BITS);
            sig_good  <= 1'b0;
            sig_bad   <= 1'b0;
            done      <= 1'b0;
            sig_ok    <= 1'b0;
            cfg_we    <= 1'b0;
            cfg_addr  <= '0;
            cfg_wdata <= '0;
        end else begin
            cfg_we <= 1'b0;
            if (state == ST_IDLE && req_any) begin
                scope    <= load_full_req ? SCOPE_FULL : SCOPE_MAC;
                end_bits <= load_full_req ? CNT_W'(FULL_BITS) : CNT_W'(MAC_BITS);
                sig_good <= 1'b0;
                sig_bad  <= 1'b0;
                done     <= 1'b0;
                sig_ok   <= 1'b0;
            end
            if (sh_sample && byte_last_bit) begin
                if (byte_num == '0) begin
                    sig_good <= (rx_byte == IMG_SIGNATURE);
                    sig_bad  <= (rx_byte != IMG_SIGNATURE);
                end else if (sig_good) begin
                    cfg_we    <= 1'b1;
                    cfg_addr  <= byte_num[REG_AW-1:0];
                    cfg_wdata <= rx_byte;
                end
            end
            if (state == ST_FINISH) begin
                done   <= 1'b1;
                sig_ok <= sig_good;
            end
        end
    end

    // Timing monitors for the chip-select windows
    logic [15:0] cs_age, hold_age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_age   <= '0;
            hold_age <= '0;
        end else begin
            if (!eep_cs)                cs_age <= '0;
            else if (cs_age != 16'hFFFF) cs_age <= cs_age + 1'b1;
            if (eep_sk || !eep_cs)        hold_age <= '0;
            else if (hold_age != 16'hFFFF) hold_age <= hold_age + 1'b1;
        end
    end

    // R3
    sk_only_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eep_sk |-> eep_cs);

    // R3
    cs_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eep_sk) |-> (cs_age >= 16'(CS_SETUP_CYC)));

    // R3
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eep_cs) |-> (hold_age >= 16'(CS_HOLD_CYC)));

    // R2
    do_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eep_sk && $past(eep_sk)) |-> $stable(eep_do));

    // R5
    we_needs_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> (busy && sig_good && in_data));

    // R6
    bad_sig_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sig_bad |-> !cfg_we);

    // R7
    mac_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && scope == SCOPE_MAC) |->
            (cfg_addr >= REG_AW'(1) && cfg_addr <= REG_AW'(MAC_LAST_BYTE)));

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R9
    scope_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(scope));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!eep_cs && !eep_sk && !cfg_we));

endmodule

// File: tb/cfg_eeprom_loader_test.sv
module cfg_eeprom_loader_test;

    localparam int ADDR_W   = 6;
    localparam int IMG      = 12;
    localparam int HALF     = 2;
    localparam int SETUP    = 3;
    localparam int HOLD     = 2;
    localparam int CMD_BITS = 3 + ADDR_W;
    localparam int RAW      = $clog2(IMG);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_full_req = 1'b0;
    logic load_mac_req = 1'b0;
    logic eep_di = 1'b0;
    logic eep_cs, eep_sk, eep_do, busy, done, sig_ok, cfg_we;
    logic [RAW-1:0] cfg_addr;
    logic [7:0] cfg_wdata;

    always #10 clk = ~clk;

    cfg_eeprom_loader #(
        .ADDR_W(ADDR_W), .IMG_BYTES(IMG), .HALF_CYC(HALF),
        .CS_SETUP_CYC(SETUP), .CS_HOLD_CYC(HOLD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .load_full_req(load_full_req),
        .load_mac_req(load_mac_req), .eep_di(eep_di), .eep_cs(eep_cs),
        .eep_sk(eep_sk), .eep_do(eep_do), .busy(busy), .done(done),
        .sig_ok(sig_ok), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Serial EEPROM model: captures command on rising clock, streams bytes
    logic [7:0]          mem [0:63];
    logic [CMD_BITS-1:0] m_cmd, cmd_seen;
    logic [ADDR_W-1:0]   m_addr;
    int m_cnt = 0;
    int m_bit = 7;
    int sk_edges = 0;

    always @(posedge eep_sk) begin
        sk_edges++;
        if (m_cnt < CMD_BITS) begin
            m_cmd = {m_cmd[CMD_BITS-2:0], eep_do};
            m_cnt++;
            if (m_cnt == CMD_BITS) begin
                m_addr = m_cmd[ADDR_W-1:0];
                m_bit  = 7;
                eep_di = mem[m_addr][7];
            end
        end else begin
            if (m_bit == 0) begin
                m_addr = m_addr + 1'b1;
                m_bit  = 7;
            end else begin
                m_bit--;
            end
            eep_di = mem[m_addr][m_bit];
        end
    end

    always @(negedge eep_cs) begin
        cmd_seen = m_cmd;
        m_cnt = 0;
    end

    // Port monitor
    int busy_cyc = 0;
    int wr_n = 0;
    int wr_addr [0:15];
    int wr_data [0:15];
    int cs_cnt = 0;
    int low_cnt = 0;
    bit seen_rise = 0;
    bit setup_bad = 0;
    bit hold_bad = 0;
    logic prev_sk = 1'b0;
    logic prev_cs = 1'b0;

    always @(negedge clk) begin
        if (busy) busy_cyc++;
        if (cfg_we && wr_n < 16) begin
            wr_addr[wr_n] = int'(cfg_addr);
            wr_data[wr_n] = int'(cfg_wdata);
            wr_n++;
        end
        if (eep_sk && !prev_sk && !seen_rise) begin
            if (cs_cnt < SETUP) setup_bad = 1;
            seen_rise = 1;
        end
        if (prev_cs && !eep_cs && low_cnt < HOLD) hold_bad = 1;
        if (eep_cs) cs_cnt++; else begin cs_cnt = 0; seen_rise = 0; end
        if (eep_sk || !eep_cs) low_cnt = 0; else low_cnt++;
        prev_sk = eep_sk;
        prev_cs = eep_cs;
    end

    task automatic set_image(input logic [7:0] sig, input int seed);
        mem[0] = sig;
        for (int k = 1; k < 64; k++) mem[k] = 8'(k * 29 + seed * 7 + 3);
    endtask

    task automatic run_load(input bit use_mac, input bit both, input bit stray,
                            input bit exp_sig);
        int nbytes, edges, exp_wr, exp_busy, wait_n;
        bit data_ok;
        nbytes = !exp_sig ? 1 : ((use_mac && !both) ? 7 : IMG);
        edges = CMD_BITS + 8 * nbytes;
        exp_wr = exp_sig ? nbytes - 1 : 0;
        exp_busy = SETUP + edges * 2 * HALF + HOLD + 1;
        @(negedge clk);
        busy_cyc = 0; wr_n = 0; sk_edges = 0; setup_bad = 0; hold_bad = 0;
        load_full_req = both || !use_mac;
        load_mac_req = both || use_mac;
        @(negedge clk);
        load_full_req = 1'b0;
        load_mac_req = 1'b0;
        // R10 done and sig_ok clear when a load starts
        chk(!done && !sig_ok && busy, "R10", "flags clear on start",
            int'({done, sig_ok, busy}), 1);
        if (stray) begin
            repeat (10) @(negedge clk);
            load_full_req = use_mac;
            load_mac_req = !use_mac;
            @(negedge clk);
            load_full_req = 1'b0;
            load_mac_req = 1'b0;
        end
        wait_n = 0;
        while (!done && wait_n < 5000) begin
            @(negedge clk);
            wait_n++;
        end
        chk(done && !busy, "R8", "done after load", int'({done, busy}), 2);
        chk(busy_cyc == exp_busy, "R8", "busy cycles", busy_cyc, exp_busy);
        chk(sig_ok == exp_sig, exp_sig ? "R5" : "R6", "sig_ok",
            int'(sig_ok), int'(exp_sig));
        chk(sk_edges == edges, "R4", "rising clock edges", sk_edges, edges);
        chk(cmd_seen == {3'b110, {ADDR_W{1'b0}}}, "R2", "read command",
            int'(cmd_seen), int'({3'b110, {ADDR_W{1'b0}}}));
        chk(!setup_bad && !hold_bad, "R3", "cs setup/hold windows",
            int'({setup_bad, hold_bad}), 0);
        chk(wr_n == exp_wr, use_mac && !both ? "R7" : (exp_sig ? "R5" : "R6"),
            "write count", wr_n, exp_wr);
        data_ok = 1;
        for (int i = 0; i < wr_n && i < 16; i++) begin
            if (wr_addr[i] != i + 1 || wr_data[i] != int'(mem[i + 1])) data_ok = 0;
        end
        chk(data_ok, stray ? "R9" : "R5", "write addresses and data",
            int'(data_ok), 1);
        repeat (3) @(negedge clk);
        chk(done && sig_ok == exp_sig, "R10", "flags hold after load",
            int'({done, sig_ok}), int'({1'b1, exp_sig}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] bad;
        set_image(8'hA5, 0);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!eep_cs && !eep_sk && !busy && !done && !sig_ok && !cfg_we, "R1",
            "outputs in reset", int'({eep_cs, eep_sk, busy, done, sig_ok, cfg_we}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!eep_cs && !eep_sk && !busy && !done && !sig_ok && !cfg_we, "R1",
            "outputs idle after reset", int'({eep_cs, eep_sk, busy, done, sig_ok, cfg_we}), 0);

        // Good signature, both scopes, several images (R4, R5, R7)
        for (int seed = 0; seed < 4; seed++) begin
            set_image(8'hA5, seed);
            run_load(1'b0, 1'b0, 1'b0, 1'b1);
            run_load(1'b1, 1'b0, 1'b0, 1'b1);
        end

        // Every single-bit corruption of the signature, plus all-0 and all-1 (R6)
        for (int b = 0; b < 10; b++) begin
            bad = (b < 8) ? (8'hA5 ^ (8'h01 << b)) : ((b == 8) ? 8'h00 : 8'hFF);
            set_image(bad, b);
            run_load(1'b0, 1'b0, 1'b0, 1'b0);
            run_load(1'b1, 1'b0, 1'b0, 1'b0);
        end

        // R9 simultaneous requests choose full scope; requests while busy ignored
        set_image(8'hA5, 9);
        run_load(1'b1, 1'b1, 1'b0, 1'b1);
        run_load(1'b0, 1'b0, 1'b1, 1'b1);
        run_load(1'b1, 1'b0, 1'b1, 1'b1);
        set_image(8'h5A, 2);
        run_load(1'b0, 1'b0, 1'b1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule